// File: doc/BRIEF.md
# I2C Interrupt Vector and Status Unit

This unit sits beside an I2C controller core and turns the core's single-cycle event pulses into sticky status flags. Seven event sources are tracked: arbitration lost, no-acknowledge, access ready, receive data ready, transmit data ready, stop detected and addressed as slave. Each flag is gated by an enable mask. The unit reports the most urgent enabled pending event as a small numeric vector code, and it drives one registered interrupt line.

Software services the controller by reading the vector register again and again until it returns 0. Every serviced event must therefore leave the vector. A flag is cleared in one of three ways, depending on the source:
- write-one-to-clear on the status register;
- a side-effect of reading the vector;
- the data-register read or write strobe of the core.

The status word also shows the bus-busy level and the receive-shift-full level. Neither of these is an interrupt source.

Top module: `i2c_irq_vec_unit`

## Requirements
- R1: While reset is asserted and right after it, status_o, mask_o, vec_o and irq_o are all 0.
- R2: A one-cycle pulse on ev_i[k] sets status bit k at the next clock edge, and the bit stays set until one of its clear actions occurs. The bit positions are: arbitration lost 0, no-acknowledge 1, access ready 2, receive ready 3, transmit ready 4, stop detected 5, addressed as slave 6.
- R3: vec_o and a read of the vector register (offset 0x28, code in bits 2:0, upper bits 0) give code k+1 for the lowest set bit k of (status AND mask) over bits 0..6. Lower codes win, so arbitration lost = 1 is the most urgent. The code is 0 when nothing enabled is pending. A pending but disabled flag still shows in the status word.
- R4: A write to the status register (offset 0x08) clears bit 2, bit 3 and bit 5 wherever the written data holds a 1. A 0 in the written data has no effect, and the write never changes bits 0, 1, 4 or 6.
- R5: A read of the vector register returns the current code in the same cycle. If that code is 1, 2 or 7, the matching status bit is cleared at the next edge. Codes 3 to 6 and code 0 leave the status unchanged.
- R6: data_rd_i clears status bit 3 (receive ready), and data_wr_i clears status bit 4 (transmit ready).
- R7: irq_o is registered. It equals the OR over bits 0..6 of (status AND mask) as they stood one cycle earlier.
- R8: When an event pulse and a clear of the same bit fall in the same cycle, the event wins and the bit stays set.
- R9: Status bit 12 follows bus_busy_i and bit 11 follows rx_shift_full_i, both without delay. Neither affects vec_o or irq_o. Status bits 7 to 10 and 13 to 15 read 0.
- R10: The mask register is at offset 0x04. Bits 0..6 are read/write and the upper bits read 0. A read at any other offset returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ev_i | input | 7 | One-cycle event pulses, bit k = source k |
| bus_busy_i | input | 1 | Bus-busy level from the core |
| rx_shift_full_i | input | 1 | Receive-shift-full level from the core |
| data_rd_i | input | 1 | Data-register read strobe |
| data_wr_i | input | 1 | Data-register write strobe |
| reg_addr_i | input | 8 | Register byte offset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_wdata_i | input | 16 | Register write data |
| reg_rdata_o | output | 16 | Register read data, combinational |
| status_o | output | 16 | Status word |
| mask_o | output | 16 | Enable mask word |
| vec_o | output | 3 | Current vector code |
| irq_o | output | 1 | Interrupt line |

## Verification
The assertions assume that reg_wr_i and reg_rd_i are never high in the same cycle. They also assume that every change of reg_addr_i comes together with its strobe, so that a read strobe aimed at the vector offset belongs to one intended read. The bench drives each register access as a single-cycle strobe that starts on a falling edge. It drives the data strobes and event pulses the same way. It makes a clear coincide with an event only where it checks the event-wins rule on purpose.

// File: rtl/i2c_irq_pkg.sv
package i2c_irq_pkg;
  localparam int NUM_SRC = 7;
  localparam int DATA_W  = 16;
  localparam int ADDR_W  = 8;
  localparam int CODE_W  = $clog2(NUM_SRC + 1);

  // source bit positions, also give vector code = position + 1
  localparam int BIT_ARB  = 0;
  localparam int BIT_NACK = 1;
  localparam int BIT_ACC  = 2;
  localparam int BIT_RX   = 3;
  localparam int BIT_TX   = 4;
  localparam int BIT_STOP = 5;
  localparam int BIT_SLV  = 6;
  localparam int BIT_RSF  = 11;
  localparam int BIT_BB   = 12;

  localparam logic [ADDR_W-1:0] OFF_MASK = 8'h04;
  localparam logic [ADDR_W-1:0] OFF_STAT = 8'h08;
  localparam logic [ADDR_W-1:0] OFF_VEC  = 8'h28;

  localparam logic [NUM_SRC-1:0] W1C_BITS =
    NUM_SRC'((1 << BIT_ACC) | (1 << BIT_RX) | (1 << BIT_STOP));
  localparam logic [NUM_SRC-1:0] VRD_BITS =
    NUM_SRC'((1 << BIT_ARB) | (1 << BIT_NACK) | (1 << BIT_SLV));
endpackage

// File: rtl/i2c_irq_flags.sv
module i2c_irq_flags #(
  parameter int N = 7
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] flag_o
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    logic q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q <= 1'b0;
      else         q <= set_i[i] | (q & ~clr_i[i]);  // set wins
    end
    assign flag_o[i] = q;
  end
endmodule

// File: rtl/i2c_irq_prio.sv
module i2c_irq_prio #(
  parameter int N      = 7,
  parameter int CODE_W = $clog2(N + 1)
) (
  input  logic [N-1:0]      pend_i,
  output logic [CODE_W-1:0] code_o,
  output logic [N-1:0]      sel_o
);
  always_comb begin
    code_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (pend_i[i]) code_o = CODE_W'(i + 1);
    end
  end

  for (genvar i = 0; i < N; i++) begin : g_sel
    assign sel_o[i] = (code_o == CODE_W'(i + 1));
  end
endmodule

// File: rtl/i2c_irq_regs.sv
module i2c_irq_regs
  import i2c_irq_pkg::*;
#(
  parameter int N  = NUM_SRC,
  parameter int DW = DATA_W,
  parameter int AW = ADDR_W,
  parameter int CW = CODE_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] addr_i,
  input  logic          wr_i,
  input  logic          rd_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [DW-1:0] status_i,
  input  logic [CW-1:0] code_i,
  output logic [DW-1:0] mask_o,
  output logic [DW-1:0] rdata_o
);
  localparam logic [DW-1:0] MASK_RW = DW'((1 << N) - 1);

  logic [DW-1:0] mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        mask_q <= '0;
    else if (wr_i && addr_i == OFF_MASK) mask_q <= wdata_i & MASK_RW;
  end

  always_comb begin
    rdata_o = '0;
    if (rd_i) begin
      unique case (addr_i)
        OFF_MASK: rdata_o = mask_q;
        OFF_STAT: rdata_o = status_i;
        OFF_VEC:  rdata_o = DW'(code_i);
        default:  rdata_o = '0;
      endcase
    end
  end

  assign mask_o = mask_q;
endmodule

// File: rtl/i2c_irq_vec_unit.sv
module i2c_irq_vec_unit
  import i2c_irq_pkg::*;
#(
  parameter int N  = NUM_SRC,
  parameter int DW = DATA_W,
  parameter int AW = ADDR_W,
  parameter int CW = CODE_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [N-1:0]  ev_i,
  input  logic          bus_busy_i,
  input  logic          rx_shift_full_i,
  input  logic          data_rd_i,
  input  logic          data_wr_i,
  input  logic [AW-1:0] reg_addr_i,
  input  logic          reg_wr_i,
  input  logic          reg_rd_i,
  input  logic [DW-1:0] reg_wdata_i,
  output logic [DW-1:0] reg_rdata_o,
  output logic [DW-1:0] status_o,
  output logic [DW-1:0] mask_o,
  output logic [CW-1:0] vec_o,
  output logic          irq_o
);
  logic [N-1:0]  flags, pend, sel, clr;
  logic [DW-1:0] status_w;
  logic          stat_wr, vec_rd, irq_q;

  assign stat_wr = reg_wr_i && (reg_addr_i == OFF_STAT);
  assign vec_rd  = reg_rd_i && (reg_addr_i == OFF_VEC);

  // clear sources per bit
  always_comb begin
    clr = '0;
    if (stat_wr) clr = clr | (reg_wdata_i[N-1:0] & W1C_BITS);
    if (vec_rd)  clr = clr | (sel & VRD_BITS);
    clr[BIT_RX] = clr[BIT_RX] | data_rd_i;
    clr[BIT_TX] = clr[BIT_TX] | data_wr_i;
  end

  i2c_irq_flags #(.N(N)) u_flags (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (ev_i),
    .clr_i  (clr),
    .flag_o (flags)
  );

  assign pend = flags & mask_o[N-1:0];

  i2c_irq_prio #(.N(N), .CODE_W(CW)) u_prio (
    .pend_i (pend),
    .code_o (vec_o),
    .sel_o  (sel)
  );

  always_comb begin
    status_w          = '0;
    status_w[N-1:0]   = flags;
    status_w[BIT_RSF] = rx_shift_full_i;
    status_w[BIT_BB]  = bus_busy_i;
  end

  i2c_irq_regs #(.N(N), .DW(DW), .AW(AW), .CW(CW)) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .addr_i   (reg_addr_i),
    .wr_i     (reg_wr_i),
    .rd_i     (reg_rd_i),
    .wdata_i  (reg_wdata_i),
    .status_i (status_w),
    .code_i   (vec_o),
    .mask_o   (mask_o),
    .rdata_o  (reg_rdata_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= |pend;
  end

  assign irq_o    = irq_q;
  assign status_o = status_w;
endmodule

// File: rtl/i2c_irq_vec_chk.sv
module i2c_irq_vec_chk
  import i2c_irq_pkg::*;
(
  input logic                clk_i,
  input logic                rst_ni,
  input logic [NUM_SRC-1:0]  ev_i,
  input logic                bus_busy_i,
  input logic                data_rd_i,
  input logic                data_wr_i,
  input logic [ADDR_W-1:0]   reg_addr_i,
  input logic                reg_wr_i,
  input logic                reg_rd_i,
  input logic [DATA_W-1:0]   reg_wdata_i,
  input logic [DATA_W-1:0]   status_o,
  input logic [DATA_W-1:0]   mask_o,
  input logic [CODE_W-1:0]   vec_o,
  input logic                irq_o
);
  logic [NUM_SRC-1:0] pend, below;
  logic               vrd, swr;

  assign pend = status_o[NUM_SRC-1:0] & mask_o[NUM_SRC-1:0];
  assign vrd  = reg_rd_i && reg_addr_i == OFF_VEC;
  assign swr  = reg_wr_i && reg_addr_i == OFF_STAT;

  always_comb begin
    below = '0;
    for (int i = 0; i < NUM_SRC; i++) below[i] = (int'(vec_o) > i + 1);
  end

  // R3
  a_r3_zero_when_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vec_o == 0) == (pend == 0));
  a_r3_lowest_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vec_o != 0) |-> (pend[vec_o - 1] && (pend & below) == 0));
  // R7
  a_r7_irq_registered: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> irq_o == $past(|pend));
  // R2, R8
  a_r8_event_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ev_i != 0) |=> ((status_o[NUM_SRC-1:0] & $past(ev_i)) == $past(ev_i)));
  // R5
  a_r5_arb_clear_by_vec: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(status_o[BIT_ARB]) |-> $past(vrd && vec_o == 1));
  // R6
  a_r6_tx_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(status_o[BIT_TX]) |-> $past(data_wr_i));
  a_r6_rx_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(status_o[BIT_RX]) |-> $past(data_rd_i || (swr && reg_wdata_i[BIT_RX])));
  // R9
  a_r9_busy_view: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[BIT_BB] == bus_busy_i);
  // R10
  a_r10_mask_upper_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mask_o[DATA_W-1:NUM_SRC] == 0);
endmodule

bind i2c_irq_vec_unit i2c_irq_vec_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .ev_i        (ev_i),
  .bus_busy_i  (bus_busy_i),
  .data_rd_i   (data_rd_i),
  .data_wr_i   (data_wr_i),
  .reg_addr_i  (reg_addr_i),
  .reg_wr_i    (reg_wr_i),
  .reg_rd_i    (reg_rd_i),
  .reg_wdata_i (reg_wdata_i),
  .status_o    (status_o),
  .mask_o      (mask_o),
  .vec_o       (vec_o),
  .irq_o       (irq_o)
);

// File: tb/i2c_irq_vec_unit_tb_top.sv
module i2c_irq_vec_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [6:0]  ev = '0;
  logic        bb = 1'b0, rsf = 1'b0, drd = 1'b0, dwr = 1'b0;
  logic [7:0]  addr = '0;
  logic        wr = 1'b0, rd = 1'b0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata, status, mask;
  logic [2:0]  vec;
  logic        irq;
  int checks = 0, errors = 0;
  bit done = 0;

  localparam logic [7:0] A_MASK = 8'h04, A_STAT = 8'h08, A_VEC = 8'h28;

  always #10 clk = ~clk;

  i2c_irq_vec_unit dut_i (
    .clk_i(clk), .rst_ni(rst_n), .ev_i(ev), .bus_busy_i(bb),
    .rx_shift_full_i(rsf), .data_rd_i(drd), .data_wr_i(dwr),
    .reg_addr_i(addr), .reg_wr_i(wr), .reg_rd_i(rd), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .status_o(status), .mask_o(mask), .vec_o(vec),
    .irq_o(irq)
  );

  task automatic chk(string req, string what, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic pulse(logic [6:0] e);
    ev = e; @(negedge clk); ev = '0;
  endtask
  task automatic wreg(logic [7:0] a, logic [15:0] d);
    addr = a; wdata = d; wr = 1'b1; @(negedge clk); wr = 1'b0;
  endtask
  task automatic rreg(logic [7:0] a, output logic [15:0] d);
    addr = a; rd = 1'b1; #1 d = rdata; @(negedge clk); rd = 1'b0;
  endtask
  task automatic dstrobe(bit r, bit w);
    drd = r; dwr = w; @(negedge clk); drd = 1'b0; dwr = 1'b0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1", "status in reset", status, 16'h0);
    chk("R1", "mask in reset", mask, 16'h0);
    chk("R1", "vec in reset", {13'b0, vec}, 16'h0);
    chk("R1", "irq in reset", {15'b0, irq}, 16'h0);
    rst_n = 1'b1; @(negedge clk);
    chk("R1", "status after reset", status, 16'h0);
  endtask

  task automatic t_mask_rw();
    logic [15:0] d;
    wreg(A_MASK, 16'hFFFF);
    rreg(A_MASK, d);
    chk("R10", "mask readback", d, 16'h007F);
    rreg(8'h10, d);
    chk("R10", "unmapped read", d, 16'h0);
  endtask

  task automatic t_sticky_irq();
    pulse(7'h20);
    chk("R2", "stop flag set", status, 16'h0020);
    chk("R7", "irq not yet", {15'b0, irq}, 16'h0);
    @(negedge clk);
    chk("R7", "irq one cycle later", {15'b0, irq}, 16'h1);
    repeat (3) @(negedge clk);
    chk("R2", "stop flag sticky", status, 16'h0020);
    chk("R3", "stop code", {13'b0, vec}, 16'd6);
    wreg(A_STAT, 16'h0020);
    chk("R4", "stop w1c", status, 16'h0);
    chk("R7", "irq lags clear", {15'b0, irq}, 16'h1);
    @(negedge clk);
    chk("R7", "irq dropped", {15'b0, irq}, 16'h0);
  endtask

  task automatic t_priority();
    logic [15:0] d;
    pulse(7'h7F);
    chk("R2", "all flags", status, 16'h007F);
    rreg(A_VEC, d); chk("R5", "vec read arb", d, 16'd1);
    chk("R5", "arb cleared", status, 16'h007E);
    rreg(A_VEC, d); chk("R5", "vec read nack", d, 16'd2);
    chk("R5", "nack cleared", status, 16'h007C);
    rreg(A_VEC, d); chk("R5", "vec read acc", d, 16'd3);
    chk("R5", "acc not cleared by read", status, 16'h007C);
    wreg(A_STAT, 16'h0004);
    chk("R4", "acc w1c", status, 16'h0078);
    chk("R3", "rx code", {13'b0, vec}, 16'd4);
    dstrobe(1'b1, 1'b0);
    chk("R6", "rx by data read", status, 16'h0070);
    chk("R3", "tx code", {13'b0, vec}, 16'd5);
    dstrobe(1'b0, 1'b1);
    chk("R6", "tx by data write", status, 16'h0060);
    wreg(A_STAT, 16'h0020);
    chk("R3", "slave code", {13'b0, vec}, 16'd7);
    rreg(A_VEC, d); chk("R5", "vec read slave", d, 16'd7);
    chk("R5", "slave cleared", status, 16'h0);
    chk("R3", "idle code", {13'b0, vec}, 16'd0);
  endtask

  task automatic t_w1c_zero();
    logic [15:0] d;
    pulse(7'h7F);
    wreg(A_STAT, 16'h0000);
    chk("R4", "write zero no effect", status, 16'h007F);
    wreg(A_STAT, 16'hFFFF);
    chk("R4", "w1c only acc rx stop", status, 16'h0053);
    rreg(A_VEC, d); rreg(A_VEC, d);
    dstrobe(1'b0, 1'b1);
    rreg(A_VEC, d);
    chk("R5", "cleanup empty", status, 16'h0);
  endtask

  task automatic t_masking();
    logic [15:0] d;
    wreg(A_MASK, 16'h0008);
    pulse(7'h01);
    chk("R3", "masked flag visible", status, 16'h0001);
    chk("R3", "masked flag no code", {13'b0, vec}, 16'd0);
    @(negedge clk);
    chk("R7", "masked no irq", {15'b0, irq}, 16'h0);
    rreg(A_VEC, d);
    chk("R5", "read of code 0", d, 16'h0);
    chk("R5", "code 0 read keeps flag", status, 16'h0001);
    wreg(A_MASK, 16'h007F);
    chk("R3", "unmask gives code", {13'b0, vec}, 16'd1);
    @(negedge clk);
    chk("R7", "irq after unmask", {15'b0, irq}, 16'h1);
    rreg(A_VEC, d);
    chk("R5", "arb cleared", status, 16'h0);
  endtask

  task automatic t_event_wins();
    logic [15:0] d;
    pulse(7'h20);
    ev = 7'h20; addr = A_STAT; wdata = 16'h0020; wr = 1'b1;
    @(negedge clk); ev = '0; wr = 1'b0;
    chk("R8", "stop event beats w1c", status, 16'h0020);
    wreg(A_STAT, 16'h0020);
    pulse(7'h01);
    ev = 7'h01; addr = A_VEC; rd = 1'b1;
    @(negedge clk); ev = '0; rd = 1'b0;
    chk("R8", "arb event beats vec read", status, 16'h0001);
    rreg(A_VEC, d);
    pulse(7'h08);
    ev = 7'h08; drd = 1'b1;
    @(negedge clk); ev = '0; drd = 1'b0;
    chk("R8", "rx event beats data read", status, 16'h0008);
    dstrobe(1'b1, 1'b0);
    chk("R6", "rx cleared", status, 16'h0);
  endtask

  task automatic t_levels();
    logic [15:0] d;
    bb = 1'b1; rsf = 1'b1; #1;
    chk("R9", "busy and shift-full bits", status, 16'h1800);
    rreg(A_STAT, d);
    chk("R9", "status read levels", d, 16'h1800);
    @(negedge clk);
    chk("R9", "levels raise no code", {13'b0, vec}, 16'd0);
    chk("R9", "levels raise no irq", {15'b0, irq}, 16'h0);
    bb = 1'b0; rsf = 1'b0; #1;
    chk("R9", "levels released", status, 16'h0);
  endtask

  initial begin
    t_reset();
    t_mask_rw();
    t_sticky_irq();
    t_priority();
    t_w1c_zero();
    t_masking();
    t_event_wins();
    t_levels();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule